// File: doc/BRIEF.md
# Selectable Floating-Point Order Comparator

This block compares two IEEE 754 binary values of the same format and drives one result bit. A 2-bit selector picks which relation is tested: the first operand equal to the second, strictly below it, or below-or-equal. A selector value of zero turns the output off. The block has no clock and no storage. The result follows the inputs after combinational delay only.

The comparison follows IEEE ordering on the sign/magnitude encoding. Both signed zeros count as the same value. Any NaN operand makes every relation false. Infinities sit above and below all finite values. When both operands are negative, the order of the magnitude comparison is reversed. Internally, each operand's exponent and fraction form a single unsigned magnitude. That magnitude is compared in fixed-width slices, and a priority fold over the slices, starting from the most significant, combines their results. The format width is a parameter and may be 16, 32 or 64; the exponent width follows from it.

Top module: `fp_order_cmp`

## Requirements
- R1: With `pred_sel` = 2'b00, `hit` is 0 for every pair of operands.
- R2: With `pred_sel` = 2'b01, `hit` is 1 exactly when the two operands are numerically equal and neither is NaN.
- R3: With `pred_sel` = 2'b10, `hit` is 1 exactly when `a_op` is numerically strictly less than `b_op` and neither is NaN.
- R4: With `pred_sel` = 2'b11, `hit` is 1 exactly when `a_op` is less than or equal to `b_op` and neither is NaN.
- R5: An operand is NaN when its exponent field (the bits just below the sign bit, which is the MSB) is all ones and its fraction is nonzero. If either operand is NaN, `hit` is 0 under every selector value, whatever the sign or payload of the NaN.
- R6: +0 (all bits clear) and -0 (only the MSB set) compare equal in any pairing: equal gives 1, strictly-less gives 0, less-or-equal gives 1.
- R7: A negative nonzero operand is strictly less than any positive nonzero operand, and this includes infinities of opposite sign.
- R8: When both operands are negative, the operand with the larger magnitude field is the smaller value.
- R9: Infinity (exponent all ones, fraction zero) is ordered: +inf is greater than the largest finite value and equal to itself, and -inf is less than every finite value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | FP_WIDTH | First operand, IEEE 754 encoding |
| b_op | input | FP_WIDTH | Second operand, IEEE 754 encoding |
| pred_sel | input | 2 | Relation select: 00 off, 01 equal, 10 strictly less, 11 less-or-equal |
| hit | output | 1 | 1 when the selected relation holds |

## Verification
Uniformly random bit patterns almost never produce equal values, exponent fields that are all ones, or two negative operands whose magnitudes differ only in a low slice. Those are exactly the cases where the sign reversal, the NaN gate and the slice fold can go wrong. The stimulus therefore uses directed pairs: signed zeros, both infinities, NaNs of each sign with quiet and signalling payloads, and the largest finite value. These are followed by random operands in which the second value is often a copy of the first with one low or one high bit flipped, or with only its sign flipped. This lands equal and near-equal magnitudes in every slice, under both signs.

// File: rtl/fp_cmp_pkg.sv
package fp_cmp_pkg;

  typedef enum logic [1:0] {
    PRED_OFF = 2'b00,
    PRED_EQ  = 2'b01,
    PRED_LT  = 2'b10,
    PRED_LE  = 2'b11
  } pred_e;

  // exponent field width for a supported storage width
  function automatic int exp_bits(input int w);
    if (w == 16)      return 5;
    else if (w == 64) return 11;
    else              return 8;
  endfunction

  // number of slices needed to cover a field of w bits
  function automatic int slice_count(input int w, input int s);
    return (w + s - 1) / s;
  endfunction

  // ordered relation of two signed values, NaN excluded
  function automatic logic [1:0] order_rel(input logic sa, input logic sb,
                                           input logic both_z,
                                           input logic mlt, input logic meq);
    logic lt, eq;
    if (both_z) begin
      lt = 1'b0; eq = 1'b1;
    end else if (sa != sb) begin
      lt = sa;   eq = 1'b0;
    end else if (!sa) begin
      lt = mlt;  eq = meq;
    end else begin
      lt = !mlt && !meq; eq = meq;
    end
    return {lt, eq};
  endfunction

endpackage

// File: rtl/fp_cmp_classify.sv
module fp_cmp_classify #(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd,
  output logic         sign,
  output logic         is_nan,
  output logic         is_zero,
  output logic [W-2:0] mag
);
  localparam int EW = fp_cmp_pkg::exp_bits(W);
  localparam int FW = W - 1 - EW;

  logic [EW-1:0] exp_f;
  logic [FW-1:0] frac_f;

  assign sign    = opnd[W-1];
  assign exp_f   = opnd[W-2 -: EW];
  assign frac_f  = opnd[FW-1:0];
  assign mag     = opnd[W-2:0];
  assign is_nan  = (&exp_f) && (|frac_f);
  assign is_zero = ~|mag;
endmodule

// File: rtl/fp_cmp_magnitude.sv
module fp_cmp_magnitude #(
  parameter int MW    = 31,
  parameter int SLICE = 8
) (
  input  logic [MW-1:0] ma,
  input  logic [MW-1:0] mb,
  output logic          mag_lt,
  output logic          mag_eq
);
  localparam int NS = fp_cmp_pkg::slice_count(MW, SLICE);
  localparam int PW = NS * SLICE;

  logic [PW-1:0] pa, pb;
  logic [NS-1:0] s_lt, s_eq;

  assign pa = PW'(ma);
  assign pb = PW'(mb);

  for (genvar i = 0; i < NS; i++) begin : g_slice
    assign s_lt[i] = pa[i*SLICE +: SLICE] <  pb[i*SLICE +: SLICE];
    assign s_eq[i] = pa[i*SLICE +: SLICE] == pb[i*SLICE +: SLICE];
  end

  // most significant differing slice decides
  always_comb begin
    mag_lt = 1'b0;
    mag_eq = 1'b1;
    for (int i = NS - 1; i >= 0; i--) begin
      if (mag_eq) begin
        mag_lt = s_lt[i];
        mag_eq = s_eq[i];
      end
    end
  end
endmodule

// File: rtl/fp_order_cmp.sv
module fp_order_cmp #(
  parameter int FP_WIDTH = 32,
  parameter int SLICE    = 8
) (
  input  logic [FP_WIDTH-1:0] a_op,
  input  logic [FP_WIDTH-1:0] b_op,
  input  logic [1:0]          pred_sel,
  output logic                hit
);
  import fp_cmp_pkg::*;

  localparam int MW = FP_WIDTH - 1;

  logic          sign_a, sign_b, nan_a, nan_b, zero_a, zero_b;
  logic [MW-1:0] mag_a, mag_b;
  logic          mag_lt, mag_eq;
  logic          unordered, both_zero, ord_lt, ord_eq;
  logic [1:0]    rel;

  fp_cmp_classify #(.W(FP_WIDTH)) u_cls_a (
    .opnd(a_op), .sign(sign_a), .is_nan(nan_a), .is_zero(zero_a), .mag(mag_a)
  );
  fp_cmp_classify #(.W(FP_WIDTH)) u_cls_b (
    .opnd(b_op), .sign(sign_b), .is_nan(nan_b), .is_zero(zero_b), .mag(mag_b)
  );
  fp_cmp_magnitude #(.MW(MW), .SLICE(SLICE)) u_mag (
    .ma(mag_a), .mb(mag_b), .mag_lt(mag_lt), .mag_eq(mag_eq)
  );

  assign unordered = nan_a | nan_b;
  assign both_zero = zero_a & zero_b;
  assign rel       = order_rel(sign_a, sign_b, both_zero, mag_lt, mag_eq);
  assign ord_lt    = rel[1];
  assign ord_eq    = rel[0];

  always_comb begin
    hit = 1'b0;
    if (!unordered) begin
      case (pred_e'(pred_sel))
        PRED_EQ: hit = ord_eq;
        PRED_LT: hit = ord_lt;
        PRED_LE: hit = ord_lt | ord_eq;
        default: hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fp_order_cmp_check.sv
module fp_order_cmp_check (
  input logic [1:0] pred_sel,
  input logic       hit,
  input logic       unordered,
  input logic       both_zero,
  input logic       ord_lt,
  input logic       ord_eq,
  input logic       sign_a,
  input logic       sign_b,
  input logic       mag_lt,
  input logic       mag_eq
);
  always_comb begin
    a_r1_off_low: assert (pred_sel != 2'b00 || !hit)
      else $error("R1 hit high with selector off");
    a_r5_nan_false: assert (!unordered || !hit)
      else $error("R5 hit high with NaN operand");
    a_r6_zero_equal: assert (!both_zero || (ord_eq && !ord_lt))
      else $error("R6 signed zeros not equal");
    a_r4_le_union: assert (pred_sel != 2'b11 || unordered || hit == (ord_lt || ord_eq))
      else $error("R4 less-or-equal mismatch");
    a_r2_exclusive: assert (!(ord_lt && ord_eq))
      else $error("R2 less and equal together");
    a_r7_neg_below_pos: assert (!(sign_a && !sign_b && !both_zero) || ord_lt)
      else $error("R7 negative not below positive");
    a_r8_neg_reversed: assert (!(sign_a && sign_b && !both_zero && !mag_lt && !mag_eq) || ord_lt)
      else $error("R8 negative order not reversed");
  end
endmodule

bind fp_order_cmp fp_order_cmp_check u_chk (
  .pred_sel(pred_sel), .hit(hit), .unordered(unordered), .both_zero(both_zero),
  .ord_lt(ord_lt), .ord_eq(ord_eq), .sign_a(sign_a), .sign_b(sign_b),
  .mag_lt(mag_lt), .mag_eq(mag_eq)
);

// File: tb/fp_order_cmp_bench.sv
module fp_order_cmp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int EW = 8;
  localparam int FW = W - 1 - EW;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rst;
  logic [W-1:0] a_i, b_i;
  logic [1:0]   p_i;
  logic         hit;

  fp_order_cmp #(.FP_WIDTH(W)) u_fp_order_cmp (
    .a_op(a_i), .b_op(b_i), .pred_sel(p_i), .hit(hit)
  );

  typedef struct {
    logic         exp;
    string        req;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [1:0]   p;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // independent model: map each value onto a signed integer line
  function automatic bit ref_nan(input logic [W-1:0] v);
    return (v[W-2:FW] == {EW{1'b1}}) && (v[FW-1:0] != '0);
  endfunction

  function automatic longint ref_key(input logic [W-1:0] v);
    longint m;
    m = longint'(v[W-2:0]);
    return v[W-1] ? -m : m;
  endfunction

  function automatic logic ref_hit(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [1:0] p);
    longint ka, kb;
    if (ref_nan(a) || ref_nan(b)) return 1'b0;
    ka = ref_key(a);
    kb = ref_key(b);
    case (p)
      2'b01:   return ka == kb;
      2'b10:   return ka <  kb;
      2'b11:   return ka <= kb;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string ptag(input logic [1:0] p);
    case (p)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] p, input string req);
    item_t it;
    @(negedge clk);
    a_i = a; b_i = b; p_i = p;
    it.exp = ref_hit(a, b, p);
    it.req = req; it.a = a; it.b = b; it.p = p;
    sbq.push_back(it);
  endtask

  task automatic sweep(input logic [W-1:0] a, input logic [W-1:0] b, input string extra);
    for (int p = 0; p < 4; p++) begin
      if (extra == "") drive(a, b, 2'(p), ptag(2'(p)));
      else drive(a, b, 2'(p), $sformatf("%s/%s", extra, ptag(2'(p))));
    end
  endtask

  // monitor
  always @(posedge clk) begin
    if (!rst && sbq.size() != 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (hit !== it.exp) begin
        failures++;
        $display("FAIL %s a=%h b=%h sel=%b actual=%b expected=%b",
                 it.req, it.a, it.b, it.p, hit, it.exp);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [W-1:0] PZERO = 32'h0000_0000, NZERO = 32'h8000_0000;
  localparam logic [W-1:0] ONE   = 32'h3F80_0000, TWO   = 32'h4000_0000;
  localparam logic [W-1:0] MONE  = 32'hBF80_0000, MTWO  = 32'hC000_0000;
  localparam logic [W-1:0] PINF  = 32'h7F80_0000, NINF  = 32'hFF80_0000;
  localparam logic [W-1:0] QNAN  = 32'h7FC0_0000, SNAN  = 32'h7F80_0001;
  localparam logic [W-1:0] NNAN  = 32'hFFC0_0000, MAXF  = 32'h7F7F_FFFF;
  localparam logic [W-1:0] TINY  = 32'h0000_0001;

  initial begin
    logic [31:0] x;
    rst = 1'b1;
    a_i = ONE; b_i = TWO; p_i = 2'b00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state and R1: selector off keeps output low
    drive(ONE, TWO, 2'b00, "R1 reset");
    drive(ONE, ONE, 2'b00, "R1");
    // main relations on positives
    sweep(ONE, TWO, "");
    sweep(TWO, ONE, "");
    sweep(ONE, ONE, "");
    // R6 signed zeros
    sweep(PZERO, NZERO, "R6");
    sweep(NZERO, PZERO, "R6");
    sweep(NZERO, TINY, "R6");
    // R7 negative below positive
    sweep(MONE, ONE, "R7");
    sweep(ONE, MONE, "R7");
    sweep(NINF, PINF, "R7");
    sweep(32'h8000_0001, TINY, "R7");
    // R8 both negative
    sweep(MTWO, MONE, "R8");
    sweep(MONE, MTWO, "R8");
    sweep(MONE, MONE, "R8");
    sweep(32'hBF80_0001, MONE, "R8");
    // R9 infinities
    sweep(MAXF, PINF, "R9");
    sweep(PINF, PINF, "R9");
    sweep(NINF, 32'hFF7F_FFFF, "R9");
    sweep(NINF, NINF, "R9");
    // R5 NaN operands
    sweep(QNAN, ONE, "R5");
    sweep(ONE, SNAN, "R5");
    sweep(NNAN, NNAN, "R5");
    sweep(QNAN, PINF, "R5");
    sweep(NZERO, NNAN, "R5");
    // random with near-equal partners
    x = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] ra, rb;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      ra = x;
      case (x[2:0])
        3'd0:    rb = ra;
        3'd1:    rb = ra ^ (32'h1 << x[7:3]);
        3'd2:    rb = ra ^ 32'h8000_0000;
        3'd3:    rb = ra ^ 32'h1;
        default: rb = {x[15:0], x[31:16]};
      endcase
      drive(ra, rb, x[9:8], ptag(x[9:8]));
    end
    while (sbq.size() != 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule